// File: doc/BRIEF.md
# Label-Routed Packet Bridge

The bridge moves short byte packets between one attached processing object and two point-to-point device links. Every packet opens with a destination label. A small routing table, written through a plain configuration port, maps label ranges either to the local object or to one of the two outbound links. Three ingress streams (object, link 0, link 1) share one receive buffer. Three egress streams (object, link 0, link 1) drain that buffer in arrival order.

All data interfaces are valid/ready byte streams. A byte moves on a rising clock edge where valid and ready are both high. A sender must hold valid and data until that edge. Ingress ready may depend on the offered data, because the length byte is only taken when the whole packet fits. On egress, the bridge keeps valid and data steady while the receiver holds ready low.

An ingress source is picked round-robin. After a source is picked, its packet is taken to the end before any other source is served. Packets longer than the link limit are split by the sender into several packets.

Top module: `lbr_bridge`

## Requirements
- R1: Packet format: byte 0 is the label and byte 1 is the payload length. The payload bytes follow. Route port code 0 sends the packet to the object output, code 1 to link output 0 and code 2 to link output 1. At most one output is valid in any cycle.
- R2: When several enabled table entries contain a label (base <= label <= limit), the entry with the lowest index decides the route.
- R3: A packet whose label matches no enabled entry, or whose matching entry holds port code 3, is consumed in full at its input and appears on no output.
- R4: A routed packet leaves on its output unchanged: the label, the length and all payload bytes, in order.
- R5: A length of 0 or above 62 drops the packet. The bridge still consumes that many payload bytes. `err_count` rises by one, saturating at 255.
- R6: The length byte of a routable packet is not accepted (ready low) until at least length+2 bytes of the 128-byte buffer are free.
- R7: Ingress sources are served round-robin in the cyclic order object, link 0, link 1. The search starts after the source served last.
- R8: Once a packet's label is accepted, no other source sees ready until that packet's last byte is taken. At most one ingress ready is high.
- R9: After reset, all outputs are invalid, `err_count` is 0 and every table entry is disabled, so every packet is discarded.
- R10: While an output is valid and its ready is low, the output stays valid and its data is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write one routing entry |
| cfg_idx | input | 3 | Entry index to write |
| cfg_en | input | 1 | Entry enable |
| cfg_base | input | 8 | Lowest label of the range |
| cfg_limit | input | 8 | Highest label of the range |
| cfg_port | input | 2 | Port code (0 object, 1 link 0, 2 link 1, 3 discard) |
| obj_rx_valid | input | 1 | Object to bridge byte valid |
| obj_rx_ready | output | 1 | Bridge accepts object byte |
| obj_rx_data | input | 8 | Object to bridge byte |
| lnk_rx_valid | input | 2 | Inbound link byte valid, bit n for link n |
| lnk_rx_ready | output | 2 | Bridge accepts inbound link byte |
| lnk_rx_data | input | 16 | Inbound link bytes, link n in bits 8n+7:8n |
| obj_tx_valid | output | 1 | Bridge to object byte valid |
| obj_tx_ready | input | 1 | Object accepts byte |
| obj_tx_data | output | 8 | Bridge to object byte |
| lnk_tx_valid | output | 2 | Outbound link byte valid |
| lnk_tx_ready | input | 2 | Outbound link accepts byte |
| lnk_tx_data | output | 16 | Outbound link bytes, link n in bits 8n+7:8n |
| err_count | output | 8 | Count of bad-length packets, saturating |

## Verification
The hardest state to reach is a receive buffer that is exactly full, with a third packet's length byte waiting. The bench stalls link output 1 and sends two maximum-size packets to it, which fill all 128 bytes. It then offers a one-byte packet and watches ingress ready stay low until the stall is lifted. Round-robin order is the other hard case. The bench first serves the object port, then has link 0 offer two packets back to back while link 1 offers one. The packet from link 1 must arrive between the two from link 0.

// File: rtl/lbr_pkg.sv
package lbr_pkg;
  typedef enum logic [2:0] {
    IG_IDLE, IG_LBL, IG_LEN, IG_LENW, IG_PAY, IG_DROP
  } ig_state_e;
endpackage

// File: rtl/lbr_route_table.sv
module lbr_route_table #(
  parameter int N_ENT = 8,
  parameter int LW    = 8,
  parameter int PW    = 2,
  localparam int IW   = $clog2(N_ENT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_idx,
  input  logic          cfg_en,
  input  logic [LW-1:0] cfg_base,
  input  logic [LW-1:0] cfg_limit,
  input  logic [PW-1:0] cfg_port,
  input  logic [LW-1:0] lk_label,
  output logic          lk_hit,
  output logic [PW-1:0] lk_port
);
  logic [N_ENT-1:0] en_q;
  logic [LW-1:0]    base_q  [N_ENT];
  logic [LW-1:0]    limit_q [N_ENT];
  logic [PW-1:0]    port_q  [N_ENT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0;
      for (int i = 0; i < N_ENT; i++) begin
        base_q[i]  <= '0;
        limit_q[i] <= '0;
        port_q[i]  <= '0;
      end
    end else if (cfg_we) begin
      en_q[cfg_idx]    <= cfg_en;
      base_q[cfg_idx]  <= cfg_base;
      limit_q[cfg_idx] <= cfg_limit;
      port_q[cfg_idx]  <= cfg_port;
    end
  end

  // Scan from the top entry down so the lowest matching index is applied last (R2)
  always_comb begin
    lk_hit  = 1'b0;
    lk_port = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (en_q[i] && lk_label >= base_q[i] && lk_label <= limit_q[i]) begin
        lk_hit  = 1'b1;
        lk_port = port_q[i];
      end
    end
  end
endmodule

// File: rtl/lbr_fifo.sv
module lbr_fifo #(
  parameter int DEPTH = 128,
  parameter int W     = 10,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic [W-1:0]  rd_data,
  output logic          empty,
  output logic [CW-1:0] free
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (rd_en) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CW'(wr_en) - CW'(rd_en);
    end
  end

  assign rd_data = mem[rd_ptr];
  assign empty   = (count == '0);
  assign free    = CW'(DEPTH) - count;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !rd_en |-> count < CW'(DEPTH)); // R6
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> count != '0); // R10
endmodule

// File: rtl/lbr_ingress.sv
module lbr_ingress
  import lbr_pkg::*;
#(
  parameter int N_SRC  = 3,
  parameter int DW     = 8,
  parameter int PW     = 2,
  parameter int CW     = 8,
  parameter int MAXLEN = 62,
  parameter int EW     = 8,
  localparam int SW    = $clog2(N_SRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_valid,
  input  logic [N_SRC*DW-1:0] src_data,
  output logic [N_SRC-1:0]  src_ready,
  output logic [DW-1:0]     lk_label,
  input  logic              lk_hit,
  input  logic [PW-1:0]     lk_port,
  input  logic [CW-1:0]     free,
  output logic              wr_en,
  output logic [PW+DW-1:0]  wr_data,
  output logic [EW-1:0]     err_count
);
  localparam logic [PW-1:0] DISCARD = '1;

  ig_state_e     state_q;
  logic [SW-1:0] sel_q, last_q, pick;
  logic          any_v, cur_v, rdy, bad, keep, fits;
  logic [DW-1:0] cur_d, lbl_q, len_q, cnt_q;
  logic [PW-1:0] port_q;

  always_comb begin
    any_v = 1'b0;
    pick  = sel_q;
    for (int k = 1; k <= N_SRC; k++) begin
      int idx;
      idx = (int'(last_q) + k) % N_SRC;
      if (!any_v && src_valid[idx]) begin
        any_v = 1'b1;
        pick  = SW'(idx);
      end
    end
  end

  always_comb begin
    cur_v   = src_valid[sel_q];
    cur_d   = src_data[int'(sel_q)*DW +: DW];
    bad     = (cur_d == '0) || (int'(cur_d) > MAXLEN);
    keep    = lk_hit && (lk_port != DISCARD) && !bad;
    fits    = int'(free) >= int'(cur_d) + 2;
    rdy     = 1'b0;
    wr_en   = 1'b0;
    wr_data = '0;
    case (state_q)
      IG_LBL:  rdy = 1'b1;
      IG_LEN: begin
        rdy = keep ? fits : 1'b1;
        if (rdy && cur_v && keep) begin
          wr_en   = 1'b1;
          wr_data = {lk_port, lbl_q};
        end
      end
      IG_LENW: begin
        wr_en   = 1'b1;
        wr_data = {port_q, len_q};
      end
      IG_PAY: begin
        rdy = 1'b1;
        if (cur_v) begin
          wr_en   = 1'b1;
          wr_data = {port_q, cur_d};
        end
      end
      IG_DROP: rdy = 1'b1;
      default: rdy = 1'b0;
    endcase
    src_ready = rdy ? (N_SRC'(1) << sel_q) : '0;
  end

  assign lk_label = lbl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= IG_IDLE;
      sel_q     <= '0;
      last_q    <= SW'(N_SRC - 1);
      lbl_q     <= '0;
      len_q     <= '0;
      cnt_q     <= '0;
      port_q    <= '0;
      err_count <= '0;
    end else begin
      case (state_q)
        IG_IDLE: if (any_v) begin
          sel_q   <= pick;
          last_q  <= pick;
          state_q <= IG_LBL;
        end
        IG_LBL: if (cur_v) begin
          lbl_q   <= cur_d;
          state_q <= IG_LEN;
        end
        IG_LEN: if (rdy && cur_v) begin
          len_q  <= cur_d;
          cnt_q  <= cur_d;
          port_q <= lk_port;
          if (keep) state_q <= IG_LENW;
          else begin
            if (bad && err_count != '1) err_count <= err_count + 1'b1;
            state_q <= (cur_d == '0) ? IG_IDLE : IG_DROP;
          end
        end
        IG_LENW: state_q <= IG_PAY;
        IG_PAY, IG_DROP: if (cur_v) begin
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == DW'(1)) state_q <= IG_IDLE;
        end
        default: state_q <= IG_IDLE;
      endcase
    end
  end

  AST_NO_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != IG_IDLE |=> $stable(sel_q)); // R8
  AST_ERR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (err_count == $past(err_count)) || (err_count == $past(err_count) + 1'b1)); // R5
endmodule

// File: rtl/lbr_bridge.sv
module lbr_bridge #(
  parameter int N_LINK = 2,
  parameter int DW     = 8,
  parameter int DEPTH  = 128,
  parameter int N_ENT  = 8,
  parameter int MAXLEN = 62,
  parameter int EW     = 8,
  localparam int N_SRC = N_LINK + 1,
  localparam int PW    = $clog2(N_LINK + 2),
  localparam int IW    = $clog2(N_ENT),
  localparam int CW    = $clog2(DEPTH) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [IW-1:0]      cfg_idx,
  input  logic               cfg_en,
  input  logic [DW-1:0]      cfg_base,
  input  logic [DW-1:0]      cfg_limit,
  input  logic [PW-1:0]      cfg_port,
  input  logic               obj_rx_valid,
  output logic               obj_rx_ready,
  input  logic [DW-1:0]      obj_rx_data,
  input  logic [N_LINK-1:0]  lnk_rx_valid,
  output logic [N_LINK-1:0]  lnk_rx_ready,
  input  logic [N_LINK*DW-1:0] lnk_rx_data,
  output logic               obj_tx_valid,
  input  logic               obj_tx_ready,
  output logic [DW-1:0]      obj_tx_data,
  output logic [N_LINK-1:0]  lnk_tx_valid,
  input  logic [N_LINK-1:0]  lnk_tx_ready,
  output logic [N_LINK*DW-1:0] lnk_tx_data,
  output logic [EW-1:0]      err_count
);
  logic [N_SRC-1:0]    src_ready, tx_v, tx_rdy;
  logic [DW-1:0]       lk_label;
  logic                lk_hit, wr_en, rd_en, empty;
  logic [PW-1:0]       lk_port;
  logic [CW-1:0]       free;
  logic [PW+DW-1:0]    wr_data, head;

  lbr_route_table #(.N_ENT(N_ENT), .LW(DW), .PW(PW)) u_table (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en),
    .cfg_base(cfg_base), .cfg_limit(cfg_limit), .cfg_port(cfg_port),
    .lk_label(lk_label), .lk_hit(lk_hit), .lk_port(lk_port));

  lbr_ingress #(.N_SRC(N_SRC), .DW(DW), .PW(PW), .CW(CW), .MAXLEN(MAXLEN), .EW(EW)) u_ingress (
    .clk(clk), .rst_n(rst_n),
    .src_valid({lnk_rx_valid, obj_rx_valid}), .src_data({lnk_rx_data, obj_rx_data}),
    .src_ready(src_ready), .lk_label(lk_label), .lk_hit(lk_hit), .lk_port(lk_port),
    .free(free), .wr_en(wr_en), .wr_data(wr_data), .err_count(err_count));

  lbr_fifo #(.DEPTH(DEPTH), .W(PW + DW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(head), .empty(empty), .free(free));

  assign obj_rx_ready = src_ready[0];
  assign lnk_rx_ready = src_ready[N_SRC-1:1];
  assign tx_rdy       = {lnk_tx_ready, obj_tx_ready};

  for (genvar p = 0; p < N_SRC; p++) begin : g_tx
    assign tx_v[p] = !empty && (head[PW+DW-1:DW] == PW'(p));
  end

  assign rd_en        = |(tx_v & tx_rdy);
  assign obj_tx_valid = tx_v[0];
  assign lnk_tx_valid = tx_v[N_SRC-1:1];
  assign obj_tx_data  = head[DW-1:0];
  assign lnk_tx_data  = {N_LINK{head[DW-1:0]}};

  AST_TX_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx_v)); // R1
  AST_RX_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_ready)); // R8
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_v != '0) && !rd_en |=> $stable(tx_v) && $stable(head[DW-1:0])); // R10
endmodule

// File: tb/lbr_bridge_tb.sv
`timescale 1ns/1ps
module lbr_bridge_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_en;
  logic [2:0]  cfg_idx;
  logic [7:0]  cfg_base, cfg_limit;
  logic [1:0]  cfg_port;
  logic [2:0]  src_v;
  logic [7:0]  src_d [0:2];
  logic        obj_rx_ready, obj_tx_valid, obj_tx_ready;
  logic [1:0]  lnk_rx_ready, lnk_tx_valid, lnk_tx_ready;
  logic [7:0]  obj_tx_data, err_count;
  logic [15:0] lnk_tx_data;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] cap [0:2][0:511];
  int cap_n [0:2];

  always #10 clk = ~clk;

  lbr_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en),
    .cfg_base(cfg_base), .cfg_limit(cfg_limit), .cfg_port(cfg_port),
    .obj_rx_valid(src_v[0]), .obj_rx_ready(obj_rx_ready), .obj_rx_data(src_d[0]),
    .lnk_rx_valid(src_v[2:1]), .lnk_rx_ready(lnk_rx_ready), .lnk_rx_data({src_d[2], src_d[1]}),
    .obj_tx_valid(obj_tx_valid), .obj_tx_ready(obj_tx_ready), .obj_tx_data(obj_tx_data),
    .lnk_tx_valid(lnk_tx_valid), .lnk_tx_ready(lnk_tx_ready), .lnk_tx_data(lnk_tx_data),
    .err_count(err_count));

  // Capture each accepted output byte just after the falling edge
  always begin
    @(negedge clk); #2;
    if (obj_tx_valid && obj_tx_ready) begin cap[0][cap_n[0]] = obj_tx_data; cap_n[0]++; end
    if (lnk_tx_valid[0] && lnk_tx_ready[0]) begin cap[1][cap_n[1]] = lnk_tx_data[7:0]; cap_n[1]++; end
    if (lnk_tx_valid[1] && lnk_tx_ready[1]) begin cap[2][cap_n[2]] = lnk_tx_data[15:8]; cap_n[2]++; end
  end

  // {src, label, length, expected port (3 = none)}
  localparam logic [19:0] VEC [0:8] = '{
    {2'd0, 8'h10, 8'd1,  2'd0},  // R1 local, lowest label
    {2'd1, 8'h1F, 8'd4,  2'd0},  // R1 local, range top
    {2'd2, 8'h20, 8'd3,  2'd1},  // R1 link 0
    {2'd0, 8'h3F, 8'd62, 2'd1},  // R4 longest legal payload
    {2'd1, 8'h45, 8'd5,  2'd2},  // R1 link 1
    {2'd2, 8'h19, 8'd2,  2'd0},  // R2 shadowed by lower entry
    {2'd0, 8'h65, 8'd3,  2'd3},  // R3 discard code
    {2'd1, 8'h80, 8'd2,  2'd3},  // R3 no match
    {2'd0, 8'h5F, 8'd10, 2'd2}   // R1 link 1, range top
  };

  function automatic logic [7:0] pb(int lbl, int i);
    return 8'(lbl + i * 3 + 8'h5A);
  endfunction

  function automatic logic rdy_of(int s);
    return (s == 0) ? obj_rx_ready : lnk_rx_ready[(s == 2) ? 1 : 0];
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(int s, logic [7:0] b);
    src_v[s] = 1'b1; src_d[s] = b;
    #1;
    while (!rdy_of(s)) begin @(negedge clk); #1; end
    @(negedge clk);
    src_v[s] = 1'b0;
  endtask

  task automatic send_pkt(int s, int lbl, int len);
    push(s, 8'(lbl));
    push(s, 8'(len));
    for (int i = 0; i < len; i++) push(s, pb(lbl, i));
  endtask

  task automatic check_pkt(int p, int off, int lbl, int len, string req);
    int bad_at = -1;
    if (cap_n[p] < off + len + 2) bad_at = cap_n[p];
    else if (cap[p][off] != 8'(lbl)) bad_at = off;
    else if (cap[p][off+1] != 8'(len)) bad_at = off + 1;
    else for (int i = 0; i < len; i++)
      if (bad_at < 0 && cap[p][off+2+i] != pb(lbl, i)) bad_at = off + 2 + i;
    chk(bad_at < 0, req, $sformatf("packet label %0d on port %0d, first bad byte index", lbl, p),
        bad_at, -1);
  endtask

  task automatic clear_cap();
    for (int p = 0; p < 3; p++) cap_n[p] = 0;
  endtask

  task automatic cfg(int idx, int en, int b, int l, int prt);
    cfg_we = 1; cfg_idx = 3'(idx); cfg_en = 1'(en);
    cfg_base = 8'(b); cfg_limit = 8'(l); cfg_port = 2'(prt);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL R9 watchdog: cycles %0d expected below %0d", 100000, 100000);
    finish_run();
  end

  initial begin
    rst_n = 0; src_v = '0; src_d[0] = 0; src_d[1] = 0; src_d[2] = 0;
    obj_tx_ready = 1; lnk_tx_ready = 2'b11;
    cfg_we = 0; cfg_en = 0; cfg_idx = 0; cfg_base = 0; cfg_limit = 0; cfg_port = 0;
    clear_cap();
    repeat (3) @(negedge clk);
    chk({obj_tx_valid, lnk_tx_valid} == 3'b000, "R9", "output valids in reset",
        int'({obj_tx_valid, lnk_tx_valid}), 0);
    chk(err_count == 0, "R9", "err_count in reset", err_count, 0);
    rst_n = 1;
    @(negedge clk);

    // R9: empty table discards everything
    send_pkt(0, 8'h10, 2);
    repeat (20) @(negedge clk);
    chk(cap_n[0] + cap_n[1] + cap_n[2] == 0, "R9", "bytes out with empty table",
        cap_n[0] + cap_n[1] + cap_n[2], 0);

    cfg(0, 1, 8'h10, 8'h1F, 0);
    cfg(1, 1, 8'h20, 8'h3F, 1);
    cfg(2, 1, 8'h40, 8'h5F, 2);
    cfg(3, 1, 8'h18, 8'h1B, 2);
    cfg(4, 1, 8'h60, 8'h6F, 3);

    foreach (VEC[v]) begin
      int s, lbl, len, ep;
      s = int'(VEC[v][19:18]); lbl = int'(VEC[v][17:10]);
      len = int'(VEC[v][9:2]); ep = int'(VEC[v][1:0]);
      clear_cap();
      send_pkt(s, lbl, len);
      repeat (80) @(negedge clk);
      for (int p = 0; p < 3; p++) begin
        if (p == ep) check_pkt(p, 0, lbl, len, "R4");
        else chk(cap_n[p] == 0, (ep == 3) ? "R3" : "R1",
                 $sformatf("vector %0d bytes on wrong port %0d", v, p), cap_n[p], 0);
      end
    end

    // R5: bad lengths dropped and counted, stream stays aligned
    clear_cap();
    send_pkt(1, 8'h10, 63);
    send_pkt(2, 8'h10, 0);
    send_pkt(0, 8'h11, 3);
    repeat (20) @(negedge clk);
    chk(err_count == 2, "R5", "err_count after two bad lengths", err_count, 2);
    chk(cap_n[0] == 5, "R5", "bytes out after bad lengths", cap_n[0], 5);
    check_pkt(0, 0, 8'h11, 3, "R5");

    // R6 / R10: fill the buffer exactly, third packet waits on its length byte
    clear_cap();
    lnk_tx_ready[1] = 0;
    send_pkt(0, 8'h40, 62);
    send_pkt(0, 8'h41, 62);
    push(0, 8'h42);
    src_v[0] = 1; src_d[0] = 8'd1;
    repeat (5) @(negedge clk);
    #1;
    chk(obj_rx_ready == 0, "R6", "ready on length byte with full buffer", obj_rx_ready, 0);
    chk(lnk_tx_valid[1] == 1 && cap_n[2] == 0, "R10", "held output valid, bytes taken",
        cap_n[2], 0);
    chk(lnk_tx_data[15:8] == 8'h40, "R10", "held output byte", lnk_tx_data[15:8], 8'h40);
    lnk_tx_ready[1] = 1;
    @(negedge clk);
    push(0, 8'd1);
    push(0, pb(8'h42, 0));
    repeat (200) @(negedge clk);
    check_pkt(2, 0, 8'h40, 62, "R6");
    check_pkt(2, 64, 8'h41, 62, "R6");
    check_pkt(2, 128, 8'h42, 1, "R6");

    // R7 / R8: serve object, then link 0 and link 1 contend
    send_pkt(0, 8'h12, 1);
    repeat (10) @(negedge clk);
    clear_cap();
    fork
      begin send_pkt(1, 8'h21, 2); send_pkt(1, 8'h22, 2); end
      send_pkt(2, 8'h23, 2);
    join
    repeat (30) @(negedge clk);
    check_pkt(1, 0, 8'h21, 2, "R7");
    check_pkt(1, 4, 8'h23, 2, "R7");
    check_pkt(1, 8, 8'h22, 2, "R8");

    finish_run();
  end
endmodule